// File: doc/BRIEF.md
# Flash Write Status Reporter

This block sits on the read path of a flash-like memory model. While an embedded program or erase runs, a host polls the memory to follow its progress. The block decides, on every read, whether to return plain array data or a status word. In a status word, three low bits are replaced: a data-polling bit (bit 7), a toggle bit (bit 6) and an alternate toggle bit (bit 2). Their meaning depends on the running operation and on which sector the read address falls in. The remaining bits carry array data unchanged.

The operation kind, the busy sector and the suspended sector come from an outside controller, as does the bit-7 value of the word being programmed. Each time a read strobe completes, the toggle bits that the current read class calls for are inverted. A pulse on the start input clears both toggle bits when a new operation begins. The sector of an address is its upper SECT_W bits.

Top module: `flash_wstat`

## Requirements
- R1: After reset both toggle bits are 0. During the first erase read from the busy sector, bits 6 and 2 of dout are therefore 0.
- R2: op_kind 0 (idle), or any code from 5 to 7, puts arr_data on dout unchanged.
- R3: With op_kind 1 (program) and the read address in the busy sector, dout bit 7 is the inverse of prog_poll_bit. Bit 6 inverts after every completed read. Bit 2 keeps its value.
- R4: With op_kind 2 (erase) and the read address in the busy sector, dout bit 7 is 0, and bits 6 and 2 both invert after every completed read.
- R5: With op_kind 3 (erase suspended) and the read address in the suspended sector, bits 7 and 6 read 1 and bit 2 inverts after every completed read. The stored bit-6 toggle state does not change.
- R6: With op_kind 3 and the read address outside the suspended sector, dout equals arr_data and neither toggle state changes.
- R7: With op_kind 4 (program while an erase is suspended), a read from the busy sector reports the same pattern as R3. A read from the suspended sector reports the pattern of R5. Any other read returns arr_data.
- R8: With op_kind 1 or 2 and the read address outside the busy sector, dout equals arr_data and neither toggle state changes.
- R9: A toggle happens only when rd_oe falls, once per read. The read class is the one seen in the last cycle rd_oe was high. While rd_oe stays high, the status bits hold.
- R10: A cycle with op_start high clears both toggle states to 0. This takes priority over a toggle in the same cycle.
- R11: In every status word, all bits other than 7, 6 and 2 equal arr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_kind | input | 3 | Running operation: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend |
| op_start | input | 1 | One-cycle pulse when a new operation begins |
| busy_sector | input | SECT_W | Sector being programmed or erased |
| susp_sector | input | SECT_W | Sector whose erase is suspended |
| prog_poll_bit | input | 1 | Bit 7 of the word being programmed |
| rd_addr | input | ADDR_W | Read address |
| rd_oe | input | 1 | Read strobe, high for the length of a read |
| arr_data | input | DATA_W | Array contents at rd_addr |
| dout | output | DATA_W | Read data or status word |

## Verification
The assertions take for granted that op_kind, rd_addr and the sector inputs stay stable while rd_oe is high. They also take for granted that op_start is a pulse given between reads, so that a toggle state can change only at a read end or a start. The bench drives every input on the falling clock edge. It holds address and operation for the whole strobe and pulses op_start only while rd_oe is low. Every operation code, both values of the programmed bit and every sector are swept against an arithmetic model of the two toggle states.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;

  localparam logic [2:0] OP_IDLE      = 3'd0;
  localparam logic [2:0] OP_PROG      = 3'd1;
  localparam logic [2:0] OP_ERASE     = 3'd2;
  localparam logic [2:0] OP_SUSP      = 3'd3;
  localparam logic [2:0] OP_SUSP_PROG = 3'd4;

  // status bit positions decoded by the host polling routine
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ALT_BIT  = 2;

  typedef enum logic [1:0] {
    RC_ARRAY = 2'd0,
    RC_PROG  = 2'd1,
    RC_ERASE = 2'd2,
    RC_SUSP  = 2'd3
  } rd_class_e;

endpackage

// File: rtl/flash_wstat_classify.sv
module flash_wstat_classify
  import flash_wstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SECT_W = 4
) (
  input  logic [2:0]        op_kind,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SECT_W-1:0] busy_sector,
  input  logic [SECT_W-1:0] susp_sector,
  output rd_class_e         rd_class
);

  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic [ADDR_W-1:0] addr_sector;
  logic              hit_busy;
  logic              hit_susp;

  always_comb begin
    addr_sector = rd_addr >> SECT_LSB;
    hit_busy    = (addr_sector == ADDR_W'(busy_sector));
    hit_susp    = (addr_sector == ADDR_W'(susp_sector));
  end

  always_comb begin
    rd_class = RC_ARRAY;
    case (op_kind)
      OP_PROG:      if (hit_busy) rd_class = RC_PROG;
      OP_ERASE:     if (hit_busy) rd_class = RC_ERASE;
      OP_SUSP:      if (hit_susp) rd_class = RC_SUSP;
      OP_SUSP_PROG: begin
        if (hit_busy)      rd_class = RC_PROG;
        else if (hit_susp) rd_class = RC_SUSP;
      end
      default:      rd_class = RC_ARRAY;
    endcase
  end

endmodule

// File: rtl/flash_wstat_toggle.sv
module flash_wstat_toggle
  import flash_wstat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_oe,
  input  logic      op_start,
  input  rd_class_e rd_class,
  output logic      tog6,
  output logic      tog2
);

  localparam int NTOG = 2;

  logic      rd_oe_q;
  rd_class_e cls_q, cls_d;
  logic      read_done;
  logic [NTOG-1:0] tog_en;
  logic [NTOG-1:0] tog_q, tog_d;

  // hold the class seen while the strobe is high
  always_comb begin
    cls_d     = rd_oe ? rd_class : cls_q;
    read_done = rd_oe_q & ~rd_oe;
    tog_en[0] = (cls_q == RC_PROG) || (cls_q == RC_ERASE);
    tog_en[1] = (cls_q == RC_ERASE) || (cls_q == RC_SUSP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_oe_q <= 1'b0;
      cls_q   <= RC_ARRAY;
    end else begin
      rd_oe_q <= rd_oe;
      cls_q   <= cls_d;
    end
  end

  for (genvar gi = 0; gi < NTOG; gi++) begin : g_tog
    always_comb begin
      if (op_start)                     tog_d[gi] = 1'b0;
      else if (read_done && tog_en[gi]) tog_d[gi] = ~tog_q[gi];
      else                              tog_d[gi] = tog_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_q[gi] <= 1'b0;
      else        tog_q[gi] <= tog_d[gi];
    end
  end

  assign tog6 = tog_q[0];
  assign tog2 = tog_q[1];

endmodule

// File: rtl/flash_wstat_mux.sv
module flash_wstat_mux
  import flash_wstat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  rd_class_e         rd_class,
  input  logic              tog6,
  input  logic              tog2,
  input  logic              prog_poll_bit,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dout
);

  logic poll_v, tog_v, alt_v;

  always_comb begin
    poll_v = arr_data[POLL_BIT];
    tog_v  = arr_data[TOG_BIT];
    alt_v  = arr_data[ALT_BIT];
    case (rd_class)
      RC_PROG:  begin poll_v = ~prog_poll_bit; tog_v = tog6; alt_v = tog2; end
      RC_ERASE: begin poll_v = 1'b0;           tog_v = tog6; alt_v = tog2; end
      RC_SUSP:  begin poll_v = 1'b1;           tog_v = 1'b1; alt_v = tog2; end
      default:  ;
    endcase
  end

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    if (gi == POLL_BIT) begin : g_poll
      assign dout[gi] = poll_v;
    end else if (gi == TOG_BIT) begin : g_tog
      assign dout[gi] = tog_v;
    end else if (gi == ALT_BIT) begin : g_alt
      assign dout[gi] = alt_v;
    end else begin : g_pass
      assign dout[gi] = arr_data[gi];
    end
  end

endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
  import flash_wstat_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_kind,
  input  logic              op_start,
  input  logic [SECT_W-1:0] busy_sector,
  input  logic [SECT_W-1:0] susp_sector,
  input  logic              prog_poll_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_oe,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dout
);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  rd_class_e  rd_class;
  logic       tog6, tog2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  flash_wstat_classify #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_classify (
    .op_kind     (op_kind),
    .rd_addr     (rd_addr),
    .busy_sector (busy_sector),
    .susp_sector (susp_sector),
    .rd_class    (rd_class)
  );

  flash_wstat_toggle u_toggle (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_oe    (rd_oe),
    .op_start (op_start),
    .rd_class (rd_class),
    .tog6     (tog6),
    .tog2     (tog2)
  );

  flash_wstat_mux #(.DATA_W(DATA_W)) u_mux (
    .rd_class      (rd_class),
    .tog6          (tog6),
    .tog2          (tog2),
    .prog_poll_bit (prog_poll_bit),
    .arr_data      (arr_data),
    .dout          (dout)
  );

endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk
  import flash_wstat_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_kind,
  input logic              op_start,
  input logic [SECT_W-1:0] busy_sector,
  input logic [SECT_W-1:0] susp_sector,
  input logic              prog_poll_bit,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_oe,
  input logic [DATA_W-1:0] arr_data,
  input logic [DATA_W-1:0] dout
);

  logic [ADDR_W-1:0] sec_a;
  logic in_busy, in_susp, is_prog, is_erase, is_susp, is_idle;

  always_comb begin
    sec_a    = rd_addr >> (ADDR_W - SECT_W);
    in_busy  = (sec_a == ADDR_W'(busy_sector));
    in_susp  = (sec_a == ADDR_W'(susp_sector));
    is_prog  = (op_kind == OP_PROG) || (op_kind == OP_SUSP_PROG);
    is_erase = (op_kind == OP_ERASE);
    is_susp  = (op_kind == OP_SUSP);
    is_idle  = (op_kind == OP_IDLE) || (op_kind > OP_SUSP_PROG);
  end

  AST_IDLE_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> dout == arr_data); // R2

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_prog && in_busy) |-> dout[POLL_BIT] == ~prog_poll_bit); // R3

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_erase && in_busy) |-> !dout[POLL_BIT]); // R4

  AST_SUSP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_susp && in_susp) |-> (dout[POLL_BIT] && dout[TOG_BIT])); // R5

  AST_SUSP_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (is_susp && !in_susp) |-> dout == arr_data); // R6

  AST_MISS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_kind == OP_PROG || is_erase) && !in_busy) |-> dout == arr_data); // R8

  AST_HOLD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && $past(rd_oe) && $stable(op_kind) && $stable(rd_addr) &&
     !$past(op_start) && is_erase && in_busy)
    |-> ($stable(dout[TOG_BIT]) && $stable(dout[ALT_BIT]))); // R9

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_start) && is_erase && in_busy)
    |-> (!dout[TOG_BIT] && !dout[ALT_BIT])); // R10

endmodule

bind flash_wstat flash_wstat_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SECT_W(SECT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_kind       (op_kind),
  .op_start      (op_start),
  .busy_sector   (busy_sector),
  .susp_sector   (susp_sector),
  .prog_poll_bit (prog_poll_bit),
  .rd_addr       (rd_addr),
  .rd_oe         (rd_oe),
  .arr_data      (arr_data),
  .dout          (dout)
);

// File: tb/flash_wstat_bench.sv
module flash_wstat_bench;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int SECT_W = 4;
  localparam logic [SECT_W-1:0] BUSY = 4'd3;
  localparam logic [SECT_W-1:0] SUSP = 4'd9;

  logic              clk;
  logic              rst_n;
  logic [2:0]        op_kind;
  logic              op_start;
  logic [SECT_W-1:0] busy_sector;
  logic [SECT_W-1:0] susp_sector;
  logic              prog_poll_bit;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_oe;
  logic [DATA_W-1:0] arr_data;
  logic [DATA_W-1:0] dout;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  logic m6, m2;

  flash_wstat #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_flash_wstat (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .op_start(op_start),
    .busy_sector(busy_sector), .susp_sector(susp_sector),
    .prog_poll_bit(prog_poll_bit), .rd_addr(rd_addr), .rd_oe(rd_oe),
    .arr_data(arr_data), .dout(dout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%h expected %h", req, act, exp);
    end
  endtask

  // 0 array, 1 program, 2 erase, 3 suspended pattern
  function automatic int cls_of(input int op, input int sec);
    case (op)
      1: return (sec == BUSY) ? 1 : 0;
      2: return (sec == BUSY) ? 2 : 0;
      3: return (sec == SUSP) ? 3 : 0;
      4: return (sec == BUSY) ? 1 : ((sec == SUSP) ? 3 : 0);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int op, input int c);
    if (c == 1) return (op == 4) ? "R7" : "R3";
    if (c == 2) return "R4";
    if (c == 3) return (op == 4) ? "R7" : "R5";
    if (op == 3) return "R6";
    if (op == 1 || op == 2) return "R8";
    if (op == 4) return "R7";
    return "R2";
  endfunction

  function automatic logic [DATA_W-1:0] expect_word(input int c, input logic pb,
                                                    input logic [DATA_W-1:0] a);
    logic [DATA_W-1:0] e;
    e = a;
    if (c == 1) begin e[7] = ~pb; e[6] = m6; e[2] = m2; end
    if (c == 2) begin e[7] = 1'b0; e[6] = m6; e[2] = m2; end
    if (c == 3) begin e[7] = 1'b1; e[6] = 1'b1; e[2] = m2; end
    return e;
  endfunction

  task automatic start_op(input int op);
    @(negedge clk);
    op_kind  = 3'(op);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    m6 = 1'b0;
    m2 = 1'b0;
  endtask

  task automatic do_read(input int op, input int sec, input int lo,
                         input logic [DATA_W-1:0] a, input int hold);
    int c;
    logic [DATA_W-1:0] e;
    logic [DATA_W-1:0] mask;
    c = cls_of(op, sec);
    @(negedge clk);
    rd_addr  = {4'(sec), 4'(lo)};
    arr_data = a;
    rd_oe    = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      e = expect_word(c, prog_poll_bit, a);
      chk((h == 0) ? tag_of(op, c) : "R9", dout, e);
      if (h == 0 && c != 0) begin
        mask = ~16'h00C4;
        chk("R11", dout & mask, a & mask);
      end
    end
    rd_oe = 1'b0;
    if (c == 1) m6 = ~m6;
    if (c == 2) begin m6 = ~m6; m2 = ~m2; end
    if (c == 3) m2 = ~m2;
  endtask

  initial begin
    rst_n = 1'b0; op_kind = 3'd0; op_start = 1'b0;
    busy_sector = BUSY; susp_sector = SUSP; prog_poll_bit = 1'b0;
    rd_addr = '0; rd_oe = 1'b0; arr_data = '0;
    m6 = 1'b0; m2 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state seen through an erase read with no start pulse
    op_kind = 3'd2; rd_addr = {BUSY, 4'd1}; arr_data = 16'hFFFF; rd_oe = 1'b1;
    @(negedge clk);
    chk("R1", dout, 16'hFF3B);
    rd_oe = 1'b0; m6 = 1'b1; m2 = 1'b1;
    @(negedge clk);
    op_kind = 3'd0;
    @(negedge clk);
    chk("R1", dout, 16'hFFFF);

    // full sweep of operation codes, programmed bit and sectors
    for (int op = 0; op < 8; op++) begin
      for (int pb = 0; pb < 2; pb++) begin
        prog_poll_bit = pb[0];
        start_op(op);
        for (int sec = 0; sec < 16; sec++) begin
          for (int k = 0; k < 2; k++) begin
            do_read(op, sec, k * 5 + sec,
                    16'(op * 4099 + sec * 257 + k * 73 + pb * 11),
                    1 + (sec + k) % 3);
          end
        end
      end
    end

    // R10: toggles built up, then cleared by a fresh start
    prog_poll_bit = 1'b1;
    start_op(2);
    for (int i = 0; i < 3; i++) do_read(2, BUSY, i, 16'h5A5A, 1);
    start_op(2);
    @(negedge clk);
    rd_addr = {BUSY, 4'd7}; arr_data = 16'hFFFF; rd_oe = 1'b1;
    @(negedge clk);
    chk("R10", dout, 16'hFF3B);
    rd_oe = 1'b0;

    // R5: suspended-sector reads leave the bit-6 state for a later erase read
    start_op(2);
    do_read(2, BUSY, 0, 16'h0000, 1);
    op_kind = 3'd3;
    for (int i = 0; i < 3; i++) do_read(3, SUSP, i, 16'h1234, 2);
    op_kind = 3'd2;
    do_read(2, BUSY, 2, 16'h0000, 1);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule